// File: doc/BRIEF.md
# Lockstep Low-Order Interleaved Block Memory

This block is a main-memory array made of K = 2^k word-wide banks that always work together. All banks see the same in-bank row address and the same read/write command, and they begin and end every access in the same clock cycle. The bank number of a word is given by the low-order k bits of its word address. The remaining high-order bits pick the row inside each bank. As a result, the K consecutive words of an aligned block sit in K different banks on one shared row, and one parallel access moves the whole block.

A requester sends block requests over a valid/ready handshake. For a read, every bank fetches its word in the same access, and the K words land in per-bank read latches. A selector then sends them out one beat at a time, starting at bank 0, with a last flag on the final beat. This suits a cache line fill. For a write, the requester sends K data beats that fill per-bank write latches one word at a time. Only when all K are present do the banks commit them together to the shared row. Because the latches are separate from the banks, a new request can start its bank cycle while an earlier read block is still draining. A finished read waits for the latches to empty before it overwrites them.

Top module: `ilv_mem_top`

## Requirements
- R1: Word address a is stored in bank (a mod K) at row (a >> k). A read of a block returns, on beat i, the word last written to word address base*K + i.
- R2: The low-order k bits of `req_addr` have no effect. Any request addresses the aligned block given by `req_addr[ADDR_W-1:BANK_BITS]`.
- R3: All banks receive one shared row and command. They start and finish each access in the same cycle, and a new access starts only when no bank is busy.
- R4: When the read latches are empty, the first read beat is valid exactly LAT+2 clock cycles after the request handshake.
- R5: Read beats leave in ascending bank order 0..K-1. `rd_last` is 1 only on beat K-1. While `rd_ready` is low, `rd_valid`, `rd_data` and `rd_last` hold.
- R6: After a write request, `wd_ready` is high for exactly K accepted beats, and beat i goes to bank i. The commit to the banks happens only after beat K-1, and `wd_ready` is low at all other times.
- R7: `req_ready` is low from a request handshake until that request's bank access has completed and its data has been placed. It is high otherwise.
- R8: After reset, `req_ready` is 1, `rd_valid` is 0 and `wd_ready` is 0.
- R9: A new read or write request is accepted while an earlier read block is still waiting in the latches.
- R10: A read that completes while the latches still hold undelivered beats keeps the request port stalled. It does not change the latched data, and its block is delivered after the earlier block has drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Block request offered |
| req_ready | output | 1 | Block request can be taken |
| req_write | input | 1 | 1 = write block, 0 = read block |
| req_addr | input | ADDR_W | Word address; the low BANK_BITS bits are ignored |
| wd_valid | input | 1 | Write beat offered |
| wd_ready | output | 1 | Write latches take a beat |
| wd_data | input | DATA_W | Write beat data |
| rd_valid | output | 1 | Read beat available |
| rd_ready | input | 1 | Requester takes the read beat |
| rd_data | output | DATA_W | Read beat data |
| rd_last | output | 1 | Marks the final beat of a block |

## Verification
The assertions assume that the requester follows valid/ready rules. This means it sends write beats only after a write request has been accepted, and a latency of at least one cycle is configured. The bench drives every input on the falling edge. It raises `wd_valid` only inside a write transfer and keeps the request fields stable until the handshake. It sweeps every block of a four-bank, 256-word configuration with arithmetically derived data patterns. It also stalls `rd_ready` on purpose, so that requests overlap with a draining block.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    // Default geometry of the array
    localparam int DEF_BANK_BITS = 2;
    localparam int DEF_ADDR_W    = 8;
    localparam int DEF_DATA_W    = 16;
    localparam int DEF_LAT       = 2;

    // Controller phases
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // ready for a block request
        ST_FILL = 2'd1,   // gathering write beats
        ST_BUSY = 2'd2,   // shared bank access in flight
        ST_HOLD = 2'd3    // read done, waiting for latches to drain
    } ctl_state_e;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;

    // Width of a down counter able to hold lat-1
    function automatic int cnt_width(input int lat);
        return (lat > 1) ? $clog2(lat) : 1;
    endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
    parameter int ROW_W  = 6,
    parameter int DATA_W = 16,
    parameter int LAT    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ROW_W;
    localparam int CW    = ilv_pkg::cnt_width(LAT);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [CW-1:0]     cnt;
    logic [ROW_W-1:0]  row_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic              fire_access;

    assign fire_access = busy && (cnt == '0);

    // Cycle timer: the access lands LAT edges after the start edge
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy <= 1'b1;
                cnt  <= CW'(LAT - 1);
            end else if (busy) begin
                if (cnt == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    // Storage and captured command
    always_ff @(posedge clk) begin
        if (start && !busy) begin
            row_q   <= row;
            we_q    <= we;
            wdata_q <= wdata;
        end
        if (fire_access) begin
            if (we_q) mem[row_q] <= wdata_q;
            else      rdata      <= mem[row_q];
        end
    end

endmodule

// File: rtl/ilv_wr_gather.sv
module ilv_wr_gather #(
    parameter int K      = 4,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clear,
    input  logic                      push,
    input  logic [DATA_W-1:0]         din,
    output logic                      at_last,
    output logic [K-1:0][DATA_W-1:0]  words
);
    logic [IDX_W-1:0] idx;

    assign at_last = (idx == IDX_W'(K - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx <= '0;
        end else if (push) begin
            idx <= idx + 1'b1;
        end
    end

    // One latch per bank, written in ascending order
    for (genvar b = 0; b < K; b++) begin : g_wlat
        always_ff @(posedge clk) begin
            if (push && !clear && (idx == IDX_W'(b))) begin
                words[b] <= din;
            end
        end
    end

endmodule

// File: rtl/ilv_rd_stream.sv
module ilv_rd_stream #(
    parameter int K      = 4,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic [K-1:0][DATA_W-1:0]  din,
    output logic                      full,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [DATA_W-1:0]         out_data,
    output logic                      out_last
);
    logic [K-1:0][DATA_W-1:0] lat;
    logic [IDX_W-1:0]         sel;
    logic                     beat;

    assign out_valid = full;
    assign out_data  = lat[sel];
    assign out_last  = full && (sel == IDX_W'(K - 1));
    assign beat      = full && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            sel  <= '0;
        end else if (load && !full) begin
            full <= 1'b1;
            sel  <= '0;
        end else if (beat) begin
            sel <= sel + 1'b1;
            if (sel == IDX_W'(K - 1)) full <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (load && !full) lat <= din;
    end

endmodule

// File: rtl/ilv_mem_top.sv
module ilv_mem_top #(
    parameter int BANK_BITS = ilv_pkg::DEF_BANK_BITS,
    parameter int ADDR_W    = ilv_pkg::DEF_ADDR_W,
    parameter int DATA_W    = ilv_pkg::DEF_DATA_W,
    parameter int LAT       = ilv_pkg::DEF_LAT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wd_valid,
    output logic              wd_ready,
    input  logic [DATA_W-1:0] wd_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last
);
    import ilv_pkg::*;

    localparam int K     = 1 << BANK_BITS;
    localparam int ROW_W = ADDR_W - BANK_BITS;

    ctl_state_e               state;
    op_e                      op_q;
    logic [ROW_W-1:0]         row_q;
    logic                     start_q;
    logic                     req_fire;
    logic                     wd_fire;
    logic                     wg_last;
    logic [K-1:0][DATA_W-1:0] wg_words;
    logic [K-1:0][DATA_W-1:0] bank_rdata;
    logic [K-1:0]             bank_busy;
    logic [K-1:0]             bank_done;
    logic                     done_all;
    logic                     rs_full;
    logic                     capture;
    logic                     addr_low_unused;

    // Bank number bits take no part in a block access
    assign addr_low_unused = ^req_addr[BANK_BITS-1:0];

    assign req_ready = (state == ST_IDLE);
    assign wd_ready  = (state == ST_FILL);
    assign req_fire  = req_valid && req_ready;
    assign wd_fire   = wd_valid && wd_ready;
    assign done_all  = &bank_done;
    assign capture   = ((state == ST_BUSY) && done_all && (op_q == OP_READ) && !rs_full)
                    || ((state == ST_HOLD) && !rs_full);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            op_q    <= OP_READ;
            row_q   <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_fire) begin
                        row_q <= req_addr[ADDR_W-1:BANK_BITS];
                        if (req_write) begin
                            op_q  <= OP_WRITE;
                            state <= ST_FILL;
                        end else begin
                            op_q    <= OP_READ;
                            state   <= ST_BUSY;
                            start_q <= 1'b1;
                        end
                    end
                end
                ST_FILL: begin
                    if (wd_fire && wg_last) begin
                        state   <= ST_BUSY;
                        start_q <= 1'b1;
                    end
                end
                ST_BUSY: begin
                    if (done_all) begin
                        if (op_q == OP_WRITE || !rs_full) state <= ST_IDLE;
                        else                              state <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (!rs_full) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    ilv_wr_gather #(
        .K(K), .IDX_W(BANK_BITS), .DATA_W(DATA_W)
    ) u_gather (
        .clk     (clk),
        .rst     (rst),
        .clear   (req_fire),
        .push    (wd_fire),
        .din     (wd_data),
        .at_last (wg_last),
        .words   (wg_words)
    );

    for (genvar b = 0; b < K; b++) begin : g_bank
        ilv_bank #(
            .ROW_W(ROW_W), .DATA_W(DATA_W), .LAT(LAT)
        ) u_bank (
            .clk   (clk),
            .rst   (rst),
            .start (start_q),
            .we    (op_q == OP_WRITE),
            .row   (row_q),
            .wdata (wg_words[b]),
            .busy  (bank_busy[b]),
            .done  (bank_done[b]),
            .rdata (bank_rdata[b])
        );
    end

    ilv_rd_stream #(
        .K(K), .IDX_W(BANK_BITS), .DATA_W(DATA_W)
    ) u_stream (
        .clk       (clk),
        .rst       (rst),
        .load      (capture),
        .din       (bank_rdata),
        .full      (rs_full),
        .out_valid (rd_valid),
        .out_ready (rd_ready),
        .out_data  (rd_data),
        .out_last  (rd_last)
    );

endmodule

// File: rtl/ilv_mem_chk.sv
module ilv_mem_chk #(
    parameter int BANK_BITS = 2,
    parameter int DATA_W    = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    req_ready,
    input logic                    wd_ready,
    input logic                    rd_valid,
    input logic                    rd_ready,
    input logic                    rd_last,
    input logic [DATA_W-1:0]       rd_data,
    input logic [(1<<BANK_BITS)-1:0] bank_busy,
    input logic [(1<<BANK_BITS)-1:0] bank_done,
    input logic                    bank_start
);
    localparam int K = 1 << BANK_BITS;

    logic [BANK_BITS-1:0] beat_q;

    always_ff @(posedge clk) begin
        if (rst) beat_q <= '0;
        else if (rd_valid && rd_ready) beat_q <= beat_q + 1'b1;
    end

    p_lockstep_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (bank_busy == '0) || (&bank_busy));

    p_lockstep_done_r3: assert property (@(posedge clk) disable iff (rst)
        (bank_done == '0) || (&bank_done));

    p_start_when_idle_r3: assert property (@(posedge clk) disable iff (rst)
        bank_start |-> (bank_busy == '0));

    p_ready_low_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (|bank_busy) |-> !req_ready);

    p_fill_banks_idle_r6: assert property (@(posedge clk) disable iff (rst)
        wd_ready |-> ((bank_busy == '0) && !req_ready));

    p_rd_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_last)));

    p_last_position_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (rd_last == (beat_q == BANK_BITS'(K - 1))));

endmodule

bind ilv_mem_top ilv_mem_chk #(
    .BANK_BITS(BANK_BITS), .DATA_W(DATA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .wd_ready   (wd_ready),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_last    (rd_last),
    .rd_data    (rd_data),
    .bank_busy  (bank_busy),
    .bank_done  (bank_done),
    .bank_start (start_q)
);

// File: tb/tb_ilv_mem_top.sv
module tb_ilv_mem_top;
    localparam int BANK_BITS = 2;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 16;
    localparam int LAT       = 2;
    localparam int K         = 1 << BANK_BITS;
    localparam int NBLK      = 1 << (ADDR_W - BANK_BITS);

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid, req_ready, req_write;
    logic [ADDR_W-1:0] req_addr;
    logic              wd_valid, wd_ready;
    logic [DATA_W-1:0] wd_data;
    logic              rd_valid, rd_ready, rd_last;
    logic [DATA_W-1:0] rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #4 clk = ~clk;

    ilv_mem_top #(
        .BANK_BITS(BANK_BITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(LAT)
    ) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr),
        .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .rd_last(rd_last)
    );

    function automatic logic [DATA_W-1:0] pat(input int seed, input int a);
        return DATA_W'((a * (37 + 16 * seed) + 11 + seed * 4099) & 16'hFFFF);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_req(input bit wr, input int blk, input int low);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = ADDR_W'((blk << BANK_BITS) | low);
        while (!req_ready) @(negedge clk);
        tick();
        req_valid = 1'b0;
        req_addr  = '1;
    endtask

    task automatic wr_block(input int blk, input int low, input int seed);
        send_req(1'b1, blk, low);
        check(req_ready == 1'b0, "R7 ready low after write request", req_ready, 0);
        for (int i = 0; i < K; i++) begin
            while (!wd_ready) @(negedge clk);
            wd_valid = 1'b1;
            wd_data  = pat(seed, blk * K + i);
            tick();
        end
        wd_valid = 1'b0;
        check(wd_ready == 1'b0, "R6 wd_ready drops after beat K-1", wd_ready, 0);
        while (!req_ready) @(negedge clk);
    endtask

    task automatic rd_drain(input int blk, input int seed);
        rd_ready = 1'b1;
        for (int i = 0; i < K; i++) begin
            while (!rd_valid) @(negedge clk);
            check(rd_data == pat(seed, blk * K + i), "R1 R3 R5 beat data",
                  rd_data, pat(seed, blk * K + i));
            check(rd_last == (i == K - 1), "R5 last flag", rd_last, (i == K - 1));
            tick();
        end
        rd_ready = 1'b0;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        wd_valid = 1'b0; wd_data = '0; rd_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        check(req_ready == 1'b1, "R8 req_ready", req_ready, 1);
        check(rd_valid == 1'b0, "R8 rd_valid", rd_valid, 0);
        check(wd_ready == 1'b0, "R8 wd_ready", wd_ready, 0);

        // R6 R2: fill every block, low bits varied
        for (int b = 0; b < NBLK; b++) wr_block(b, b % K, 0);

        // R1 R2 R5 sweep: read back with other low bits
        for (int b = 0; b < NBLK; b++) begin
            send_req(1'b0, b, (b + 1) % K);
            rd_drain(b, 0);
        end

        // R4 R7 latency from empty latches
        send_req(1'b0, 7, 0);
        n = 0;
        while (!rd_valid && n < 50) begin
            check(req_ready == 1'b0, "R7 ready low during bank cycle", req_ready, 0);
            tick();
            n++;
        end
        check(n == LAT + 2, "R4 first beat latency", n, LAT + 2);
        check(req_ready == 1'b1, "R7 ready back after capture", req_ready, 1);
        rd_drain(7, 0);

        // R9 R10 read overlapping an undrained block
        send_req(1'b0, 5, 3);
        while (!rd_valid) @(negedge clk);
        n = 0;
        req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_W'(9 << BANK_BITS);
        while (!req_ready && n < 50) begin tick(); n++; end
        check(n == 0, "R9 read accepted while draining", n, 0);
        tick();
        req_valid = 1'b0;
        repeat (LAT + 6) tick();
        check(req_ready == 1'b0, "R10 port stalled while latches full", req_ready, 0);
        check(rd_data == pat(0, 5 * K), "R10 latched beat unchanged", rd_data, pat(0, 5 * K));
        rd_drain(5, 0);
        rd_drain(9, 0);
        while (!req_ready) @(negedge clk);

        // R9 write overlapping an undrained read of the same block
        send_req(1'b0, 3, 2);
        while (!rd_valid) @(negedge clk);
        wr_block(3, 1, 1);
        check(rd_data == pat(0, 3 * K), "R9 old block still latched", rd_data, pat(0, 3 * K));
        rd_drain(3, 0);
        send_req(1'b0, 3, 0);
        rd_drain(3, 1);

        // R5 stall mid-block
        send_req(1'b0, 12, 0);
        rd_ready = 1'b1;
        while (!rd_valid) @(negedge clk);
        tick();
        rd_ready = 1'b0;
        repeat (4) tick();
        check(rd_data == pat(0, 12 * K + 1), "R5 hold under stall", rd_data, pat(0, 12 * K + 1));
        rd_ready = 1'b1;
        for (int i = 1; i < K; i++) begin
            check(rd_data == pat(0, 12 * K + i), "R5 resume order", rd_data, pat(0, 12 * K + i));
            tick();
        end
        rd_ready = 1'b0;
        check(rd_valid == 1'b0, "R5 stream empty after last", rd_valid, 0);

        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule